// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects sixty-four interrupt request lines, qualifies each one with its own enable bit, sensing mode and priority level, and drives a single interrupt line towards a processor. The processor talks to it over a small 32-bit register bus. Reading the vector register names the winning source. A vector value of 64 means nothing valid was waiting, and software treats that read as spurious. A write to the completion register ends the current service.

Each source is either level-sensed or edge-sensed. A level source is pending for as long as its synchronised input stays high. An edge source captures a rising edge of its synchronised input and holds it. Software clears a held edge by writing the source's setup register with the edge bit flipped and then writing the original value back.

Nesting is tracked on a small stack of service priorities. A valid vector read pushes the winner's level onto the stack. While the stack is not empty, only a strictly higher level can win. A completion write pops the stack, which brings back the level that was in force before.

Top module: `irqv_ctrl`

## Requirements
- R1: After the reset input is released, the interrupt output is low, both enable halves read 0, and a read of the vector register at byte 0x030 returns 64.
- R2: Writing to byte 0x010 enables the low-half sources (0..31) whose bits are 1, and writing to 0x018 does the same for the high half (32..63). Writing to 0x020 or 0x028 disables the sources whose bits are 1 in the low or high half. A 0 bit leaves its source unchanged. Reading 0x010 or 0x018 returns the current 32-bit enable mask of that half.
- R3: Source n has a setup register at byte 0x200 + 8*n. Bit 8 selects edge sensing (1) or level sensing (0), and bits 2:0 hold the priority level. A read returns the value that was written.
- R4: An enabled level source is reported while its input is high and stops being reported once its input has been low for a few cycles.
- R5: An enabled edge source keeps being reported after its input falls again. Writing its setup register with bit 8 inverted and then writing the original value back removes the held edge.
- R6: Among enabled pending sources, the vector read returns the one with the highest priority level. On equal levels it returns the lowest index.
- R7: A vector read returns 64 when no enabled source is pending and allowed to win.
- R8: While bit 0 of the global enable register at 0x008 is 0, the interrupt output stays low and the vector read returns 64.
- R9: After a valid vector read, only sources of strictly higher level drive the interrupt output or win a vector read. Each write to the completion register at 0x038 restores the level that was in force before the matching read.
- R10: Writing 1 to bit 0 of byte 0x000 clears the enables, setup registers, global enable, held edges and the service stack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on bus_rdata one cycle later |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_src | input | N_SRC | Asynchronous interrupt request lines |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The hardest state to reach from the ports is a nested service. In that state the priority stack holds a level, a lower or equal level source is still asserted, and a higher one arrives later. The stimulus reads the vector so that a level is pushed while its source stays high. It then checks that equal-level sources are masked, raises a higher source and reads it, and unwinds with completion writes until the equal-level tie resolves to the lower index. Held edges are reached by pulsing an input for only a few cycles, so the bench has to see the source reported after the line has already dropped.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int PRIO_W    = 3;
  localparam int EDGE_BIT  = 8;
  localparam logic [11:0] A_SOFT_RST = 12'h000;
  localparam logic [11:0] A_GEN_EN   = 12'h008;
  localparam logic [11:0] A_SET_LO   = 12'h010;
  localparam logic [11:0] A_SET_HI   = 12'h018;
  localparam logic [11:0] A_CLR_LO   = 12'h020;
  localparam logic [11:0] A_CLR_HI   = 12'h028;
  localparam logic [11:0] A_VECTOR   = 12'h030;
  localparam logic [11:0] A_EOI      = 12'h038;
  localparam logic [2:0]  SETUP_PAGE = 3'b001;

  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/irqv_src_front.sv
module irqv_src_front #(
  parameter int N_SRC       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_clr,
  input  logic [N_SRC-1:0] irq_src,
  input  logic [N_SRC-1:0] edge_mode,
  input  logic [N_SRC-1:0] latch_clr,
  output logic [N_SRC-1:0] pend
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic [SYNC_STAGES-1:0] sh_q;
    logic                   prev_q;
    logic                   latch_q;
    logic                   s;

    always_ff @(posedge clk) begin
      if (rst) sh_q <= '0;
      else     sh_q <= {sh_q[SYNC_STAGES-2:0], irq_src[i]};
    end

    assign s = sh_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q  <= 1'b0;
        latch_q <= 1'b0;
      end else begin
        prev_q <= s;
        if (soft_clr || latch_clr[i] || !edge_mode[i]) latch_q <= 1'b0;
        else if (s && !prev_q)                         latch_q <= 1'b1;
      end
    end

    assign pend[i] = edge_mode[i] ? latch_q : s;

    AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (rst)
      latch_clr[i] |=> !latch_q); // R5
  end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int N_SRC = 64,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic                   cand_valid_thr,
  input  prio_t                  thr,
  input  logic [N_SRC-1:0]       cand,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
  output logic                   win_valid,
  output logic [IDX_W-1:0]       win_idx,
  output prio_t                  win_prio
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand[i] && (!cand_valid_thr || prio[i] > thr) &&
          (!win_valid || prio[i] > win_prio)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_prio  = prio[i];
      end
    end
  end
endmodule

// File: rtl/irqv_nest_stack.sv
module irqv_nest_stack
  import irqv_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  soft_clr,
  input  logic  push,
  input  prio_t push_prio,
  input  logic  pop,
  output logic  active,
  output prio_t top_prio,
  output logic  full
);
  prio_t            mem [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (push && !full) mem[cnt_q[CNT_W-1:0] % DEPTH] <= push_prio;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_clr)            cnt_q <= '0;
    else if (push && !full)         cnt_q <= cnt_q + 1'b1;
    else if (pop && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active   = (cnt_q != '0);
  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign top_prio = active ? mem[(cnt_q - 1'b1) % DEPTH] : '0;

  AST_STACK_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    push |-> !full); // R9
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int N_SRC       = 64,
  parameter int SYNC_STAGES = 2,
  localparam int HALF       = N_SRC / 2,
  localparam int IDX_W      = $clog2(N_SRC),
  localparam int DEPTH      = 1 << PRIO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_SRC-1:0]  irq_src,
  output logic              irq_o
);
  logic [N_SRC-1:0]             en_q;
  logic [N_SRC-1:0]             edge_q;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic                         gen_q;
  logic                         soft_clr;
  logic                         setup_sel;
  logic [IDX_W-1:0]             setup_idx;
  logic [N_SRC-1:0]             latch_clr;
  logic [N_SRC-1:0]             pend;
  logic [N_SRC-1:0]             cand;
  logic                         win_valid;
  logic [IDX_W-1:0]             win_idx;
  prio_t                        win_prio;
  logic                         nest_active;
  prio_t                        nest_top;
  logic                         nest_full;
  logic                         vec_rd;
  logic                         push;
  logic                         pop;
  logic                         vec_ok;

  assign soft_clr  = bus_wr && bus_addr == A_SOFT_RST && bus_wdata[0];
  assign setup_sel = bus_addr[11:9] == SETUP_PAGE && bus_addr[2:0] == 3'b000;
  assign setup_idx = bus_addr[3 +: IDX_W];

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      en_q  <= '0;
      gen_q <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_GEN_EN: gen_q <= bus_wdata[0];
        A_SET_LO: en_q[HALF-1:0]     <= en_q[HALF-1:0] | bus_wdata[HALF-1:0];
        A_SET_HI: en_q[N_SRC-1:HALF] <= en_q[N_SRC-1:HALF] | bus_wdata[HALF-1:0];
        A_CLR_LO: en_q[HALF-1:0]     <= en_q[HALF-1:0] & ~bus_wdata[HALF-1:0];
        A_CLR_HI: en_q[N_SRC-1:HALF] <= en_q[N_SRC-1:HALF] & ~bus_wdata[HALF-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_setup
    logic hit;
    assign hit          = bus_wr && setup_sel && setup_idx == IDX_W'(i);
    assign latch_clr[i] = hit && (bus_wdata[EDGE_BIT] != edge_q[i]);

    always_ff @(posedge clk) begin
      if (rst || soft_clr) begin
        edge_q[i] <= 1'b0;
        prio_q[i] <= '0;
      end else if (hit) begin
        edge_q[i] <= bus_wdata[EDGE_BIT];
        prio_q[i] <= bus_wdata[PRIO_W-1:0];
      end
    end
  end

  irqv_src_front #(
    .N_SRC       (N_SRC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_front (
    .clk       (clk),
    .rst       (rst),
    .soft_clr  (soft_clr),
    .irq_src   (irq_src),
    .edge_mode (edge_q),
    .latch_clr (latch_clr),
    .pend      (pend)
  );

  assign cand = pend & en_q;

  irqv_arbiter #(
    .N_SRC (N_SRC)
  ) u_arb (
    .cand_valid_thr (nest_active),
    .thr            (nest_top),
    .cand           (cand),
    .prio           (prio_q),
    .win_valid      (win_valid),
    .win_idx        (win_idx),
    .win_prio       (win_prio)
  );

  assign vec_ok = gen_q && win_valid;
  assign vec_rd = bus_rd && !bus_wr && bus_addr == A_VECTOR;
  assign push   = vec_rd && vec_ok && !nest_full;
  assign pop    = bus_wr && bus_addr == A_EOI;

  irqv_nest_stack #(
    .DEPTH (DEPTH)
  ) u_stack (
    .clk       (clk),
    .rst       (rst),
    .soft_clr  (soft_clr),
    .push      (push),
    .push_prio (win_prio),
    .pop       (pop),
    .active    (nest_active),
    .top_prio  (nest_top),
    .full      (nest_full)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_clr) irq_o <= 1'b0;
    else                 irq_o <= vec_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (setup_sel) begin
        bus_rdata[EDGE_BIT]     <= edge_q[setup_idx];
        bus_rdata[PRIO_W-1:0]   <= prio_q[setup_idx];
      end else begin
        case (bus_addr)
          A_GEN_EN: bus_rdata[0]      <= gen_q;
          A_SET_LO: bus_rdata[HALF-1:0] <= en_q[HALF-1:0];
          A_SET_HI: bus_rdata[HALF-1:0] <= en_q[N_SRC-1:HALF];
          A_VECTOR: bus_rdata[IDX_W:0]  <= vec_ok ? {1'b0, win_idx} : (IDX_W+1)'(N_SRC);
          default: ;
        endcase
      end
    end
  end

  AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !gen_q |=> !irq_o); // R8
  AST_EN_SET_LO: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_SET_LO) |=>
      ((en_q[HALF-1:0] & $past(bus_wdata[HALF-1:0])) == $past(bus_wdata[HALF-1:0]))); // R2
  AST_EN_CLR_HI: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_CLR_HI) |=>
      ((en_q[N_SRC-1:HALF] & $past(bus_wdata[HALF-1:0])) == '0)); // R2
  AST_WIN_IS_CAND: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (cand[win_idx] && en_q[win_idx])); // R6
  AST_NEST_STRICT: assert property (@(posedge clk) disable iff (rst)
    (push && nest_active) |-> (win_prio > nest_top)); // R9
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (en_q == '0 && !gen_q && !nest_active)); // R10
endmodule

// File: tb/irqv_ctrl_tb.sv
`timescale 1ns/1ps
module irqv_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] irq_src;
  logic        irq_o;
  int          n_chk  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  always #4 clk = ~clk;

  irqv_ctrl u_dut (
    .clk (clk), .rst (rst), .bus_wr (bus_wr), .bus_rd (bus_rd),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .irq_src (irq_src), .irq_o (irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [11:0] setup_addr(input int n);
    return 12'(12'h200 + 8 * n);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] mask;
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; irq_src = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq_o", {31'b0, irq_o}, 32'd0);
    rd(12'h010, d); check("R1 en lo", d, 32'd0);
    rd(12'h018, d); check("R1 en hi", d, 32'd0);
    rd(12'h030, d); check("R1 vector", d, 32'd64);

    wr(12'h008, 32'd1);

    // R2 enable set sweep, one bit per write, readback per half
    mask = '0;
    for (int i = 0; i < 64; i++) begin
      wr(i < 32 ? 12'h010 : 12'h018, 32'(1) << (i % 32));
      mask[i] = 1'b1;
      rd(i < 32 ? 12'h010 : 12'h018, d);
      check("R2 set sweep", d, i < 32 ? mask[31:0] : mask[63:32]);
    end
    wr(12'h020, 32'hAAAA_AAAA); rd(12'h010, d); check("R2 clr lo", d, 32'h5555_5555);
    wr(12'h028, 32'h0000_FFFF); rd(12'h018, d); check("R2 clr hi", d, 32'hFFFF_0000);
    wr(12'h010, 32'h0); rd(12'h010, d); check("R2 zero no effect", d, 32'h5555_5555);
    wr(12'h028, 32'h0); rd(12'h018, d); check("R2 zero no effect hi", d, 32'hFFFF_0000);
    wr(12'h010, 32'hFFFF_FFFF); wr(12'h018, 32'hFFFF_FFFF);

    // R3 setup sweep: level mode, priority n mod 8
    for (int i = 0; i < 64; i++) begin
      wr(setup_addr(i), 32'(i % 8));
      rd(setup_addr(i), d);
      check("R3 setup readback", d, 32'(i % 8));
    end
    wr(setup_addr(20), 32'h104); rd(setup_addr(20), d); check("R3 edge bit", d, 32'h104);
    wr(setup_addr(20), 32'h004);

    // R4 / R6 single-source sweep
    for (int i = 0; i < 64; i++) begin
      irq_src = 64'(1) << i;
      settle();
      check("R4 irq_o high", {31'b0, irq_o}, 32'd1);
      rd(12'h030, d); check("R6 single vector", d, 32'(i));
      wr(12'h038, 32'd0);
      irq_src = '0;
      settle();
      rd(12'h030, d); check("R4 level drop R7", d, 32'd64);
    end

    // R6 pair sweep
    for (int a = 0; a < 64; a++) begin
      int b, exp;
      b = (a * 37 + 11) % 64;
      if (a != b) begin
        if ((a % 8) > (b % 8))      exp = a;
        else if ((b % 8) > (a % 8)) exp = b;
        else                        exp = (a < b) ? a : b;
        irq_src = (64'(1) << a) | (64'(1) << b);
        settle();
        rd(12'h030, d); check("R6 pair", d, 32'(exp));
        wr(12'h038, 32'd0);
        irq_src = '0;
        settle();
      end
    end

    // R8 global enable gating
    wr(12'h008, 32'd0);
    irq_src = 64'(1) << 3;
    settle();
    check("R8 irq_o off", {31'b0, irq_o}, 32'd0);
    rd(12'h030, d); check("R8 vector off", d, 32'd64);
    wr(12'h008, 32'd1);
    settle();
    check("R8 irq_o on", {31'b0, irq_o}, 32'd1);
    irq_src = '0;
    settle();

    // R5 edge latch and toggle clear
    wr(setup_addr(12), 32'h101);
    irq_src[12] = 1'b1; repeat (3) @(negedge clk); irq_src[12] = 1'b0;
    settle();
    rd(12'h030, d); check("R5 edge held", d, 32'd12);
    wr(12'h038, 32'd0);
    rd(12'h030, d); check("R5 edge still held", d, 32'd12);
    wr(12'h038, 32'd0);
    wr(setup_addr(12), 32'h001);
    wr(setup_addr(12), 32'h101);
    settle();
    rd(12'h030, d); check("R5 edge cleared", d, 32'd64);

    // R9 nesting
    wr(setup_addr(5), 32'd2); wr(setup_addr(9), 32'd2); wr(setup_addr(40), 32'd6);
    irq_src = 64'(1) << 5;
    settle();
    rd(12'h030, d); check("R9 first", d, 32'd5);
    settle();
    check("R9 equal masked irq", {31'b0, irq_o}, 32'd0);
    irq_src[9] = 1'b1;
    settle();
    rd(12'h030, d); check("R9 equal masked vec", d, 32'd64);
    irq_src[40] = 1'b1;
    settle();
    check("R9 higher irq", {31'b0, irq_o}, 32'd1);
    rd(12'h030, d); check("R9 higher vec", d, 32'd40);
    wr(12'h038, 32'd0);
    settle();
    rd(12'h030, d); check("R9 after one eoi", d, 32'd40);
    wr(12'h038, 32'd0); wr(12'h038, 32'd0);
    irq_src[40] = 1'b0;
    settle();
    rd(12'h030, d); check("R9 unwound tie", d, 32'd5);
    wr(12'h038, 32'd0);

    // R10 soft reset
    wr(12'h000, 32'd1);
    @(negedge clk);
    check("R10 irq_o", {31'b0, irq_o}, 32'd0);
    rd(12'h010, d); check("R10 en lo", d, 32'd0);
    rd(12'h018, d); check("R10 en hi", d, 32'd0);
    rd(setup_addr(40), d); check("R10 setup", d, 32'd0);
    rd(12'h008, d); check("R10 gen", d, 32'd0);
    rd(12'h030, d); check("R10 vector R7", d, 32'd64);
    irq_src = '0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule